// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block implements one microcontroller I/O port of parameterised width (8 pins by default). It holds a port data latch and three per-pin configuration banks: pin direction, input threshold selection and weak pull-up enable. Only one configuration bank can be reached at a time. A small selector register, written beforehand, picks which bank a configuration write updates and which bank the configuration read port shows.

The pin side receives raw pin levels. It drives per-pin output enable, output value, threshold select and pull-up enable controls. The analog behaviour of these controls is left to the pad ring.

Incoming pin levels pass through a synchronizer that is two flops deep, or four when the extra-stage option is set. A port read can return either these synchronized pin levels or the contents of the data latch. The choice is made by a read-source bit. In pin mode, a read-modify-write that follows a data write too closely sees the old pin level. In latch mode it always sees the value just written.

Top module: `gpio_port`

## Requirements
- R1: After reset all pins are inputs (oe_o = 0) and out_o, lvl_o and pu_o are 0. The selector is 0, the read source is pins, and the configuration read shows all ones (direction bank).
- R2: A data write is visible on out_o from the clock edge that captures it. oe_o[i] is the inverse of direction bit i, where direction bit 1 means input.
- R3: A configuration write updates only the bank chosen by the selector: 0 = direction, 1 = threshold select (drives lvl_o), 2 = pull-up enable. With selector 3 the write changes nothing.
- R4: cfg_rdata_o shows the bank chosen by the current selector value, and shows 0 for selector 3. A selector write takes effect at the next clock edge.
- R5: pu_o[i] is 1 only when pull-up bit i is 1 and pin i is an input.
- R6: With the read source at 0 and the extra-stage option off, port_rdata_o shows a pin level change two clock edges after it is applied, and not after one.
- R7: With the extra-stage option on, the same change appears after four clock edges, and not after three.
- R8: With the read source at 1, port_rdata_o equals the data latch from the edge that writes it, so back-to-back read-modify-write sequences need no idle cycles.
- R9: When an output pin is held externally at the opposite level, a pin-mode read returns the external level and a latch-mode read returns the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_we_i | input | 1 | Write strobe for the bank selector |
| sel_wdata_i | input | 2 | New selector value |
| rsrc_we_i | input | 1 | Write strobe for the read-source bit |
| rsrc_wdata_i | input | 1 | New read source: 0 pins, 1 data latch |
| dat_we_i | input | 1 | Data latch write strobe |
| dat_wdata_i | input | W | Data latch write value |
| cfg_we_i | input | 1 | Configuration write strobe to the selected bank |
| cfg_wdata_i | input | W | Configuration write value |
| sync_xtra_i | input | 1 | Adds two synchronizer stages when 1 |
| pin_i | input | W | Raw pin levels |
| cfg_rdata_o | output | W | Contents of the selected configuration bank |
| port_rdata_o | output | W | Port read value |
| oe_o | output | W | Per-pin output enable |
| out_o | output | W | Per-pin output value |
| lvl_o | output | W | Per-pin input threshold select |
| pu_o | output | W | Per-pin pull-up enable |

## Verification
The bench counts clock edges between a pin change and its appearance on the read port, both with and without the extra stages. A design with the wrong synchronizer depth would show the new level one edge early or late. It writes each bank with each selector value, including the unused code. A decoder error would corrupt a neighbouring bank or let the unused code write something. It also places a pull-up on a driven pin and drives a pin against its output value, so that an ungated pull-up or a swapped read-source mux is exposed.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    BANK_DIR  = 2'd0,
    BANK_LVL  = 2'd1,
    BANK_PU   = 2'd2,
    BANK_NONE = 2'd3
  } bank_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W     = 8,
  parameter int BASE  = 2,
  parameter int EXTRA = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         xtra_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  localparam int DEPTH = BASE + EXTRA;

  logic [W-1:0] stg_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stg
    logic [W-1:0] stg_d;
    if (s == 0) begin : g_first
      assign stg_d = d_i;
    end else begin : g_next
      assign stg_d = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d;
    end
  end

  if (EXTRA > 0) begin : g_tap_sel
    assign q_o = xtra_i ? stg_q[DEPTH-1] : stg_q[BASE-1];
  end else begin : g_tap_fix
    logic unused_xtra;
    assign unused_xtra = xtra_i;
    assign q_o = stg_q[BASE-1];
  end
endmodule

// File: rtl/gpio_cfg_bank.sv
module gpio_cfg_bank
  import gpio_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  bank_sel_e    sel_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] dir_o,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] pu_o,
  output logic [W-1:0] rdata_o
);
  logic [W-1:0] dir_q, lvl_q, pu_q;
  logic         dir_en, lvl_en, pu_en;

  always_comb begin
    dir_en = we_i && (sel_i == BANK_DIR);
    lvl_en = we_i && (sel_i == BANK_LVL);
    pu_en  = we_i && (sel_i == BANK_PU);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '1;
      lvl_q <= '0;
      pu_q  <= '0;
    end else begin
      if (dir_en) dir_q <= wdata_i;
      if (lvl_en) lvl_q <= wdata_i;
      if (pu_en)  pu_q  <= wdata_i;
    end
  end

  always_comb begin
    unique case (sel_i)
      BANK_DIR: rdata_o = dir_q;
      BANK_LVL: rdata_o = lvl_q;
      BANK_PU:  rdata_o = pu_q;
      default:  rdata_o = '0;
    endcase
  end

  assign dir_o = dir_q;
  assign lvl_o = lvl_q;
  assign pu_o  = pu_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int W          = 8,
  parameter int SYNC_BASE  = 2,
  parameter int SYNC_EXTRA = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_we_i,
  input  logic [1:0]   sel_wdata_i,
  input  logic         rsrc_we_i,
  input  logic         rsrc_wdata_i,
  input  logic         dat_we_i,
  input  logic [W-1:0] dat_wdata_i,
  input  logic         cfg_we_i,
  input  logic [W-1:0] cfg_wdata_i,
  input  logic         sync_xtra_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] cfg_rdata_o,
  output logic [W-1:0] port_rdata_o,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] out_o,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] pu_o
);
  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_q_n = rst_pipe_q[1];

  // core-side registers: next-state logic
  bank_sel_e    sel_q, sel_d;
  logic         rsrc_q, rsrc_d;
  logic [W-1:0] data_q, data_d;

  always_comb begin
    sel_d  = sel_q;
    rsrc_d = rsrc_q;
    data_d = data_q;
    if (sel_we_i)  sel_d  = bank_sel_e'(sel_wdata_i);
    if (rsrc_we_i) rsrc_d = rsrc_wdata_i;
    if (dat_we_i)  data_d = dat_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      sel_q  <= BANK_DIR;
      rsrc_q <= 1'b0;
      data_q <= '0;
    end else begin
      sel_q  <= sel_d;
      rsrc_q <= rsrc_d;
      data_q <= data_d;
    end
  end

  logic [W-1:0] dir_w, lvl_w, pu_w, pin_s;

  gpio_cfg_bank #(.W(W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .sel_i   (sel_q),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .dir_o   (dir_w),
    .lvl_o   (lvl_w),
    .pu_o    (pu_w),
    .rdata_o (cfg_rdata_o)
  );

  gpio_sync #(.W(W), .BASE(SYNC_BASE), .EXTRA(SYNC_EXTRA)) u_sync (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .xtra_i (sync_xtra_i),
    .d_i    (pin_i),
    .q_o    (pin_s)
  );

  assign oe_o         = ~dir_w;
  assign out_o        = data_q;
  assign lvl_o        = lvl_w;
  assign pu_o         = pu_w & dir_w;
  assign port_rdata_o = rsrc_q ? data_q : pin_s;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int W          = 8,
  parameter int SYNC_BASE  = 2,
  parameter int SYNC_EXTRA = 2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         dat_we_i,
  input logic [W-1:0] dat_wdata_i,
  input logic         cfg_we_i,
  input logic [1:0]   sel_q,
  input logic         rsrc_q,
  input logic         sync_xtra_i,
  input logic [W-1:0] pin_i,
  input logic [W-1:0] port_rdata_o,
  input logic [W-1:0] oe_o,
  input logic [W-1:0] out_o,
  input logic [W-1:0] lvl_o,
  input logic [W-1:0] pu_o
);
  logic [2:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              age_q <= 3'd0;
    else if (age_q != 3'd7)  age_q <= age_q + 3'd1;
  end

  // R2
  data_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dat_we_i |=> (out_o == $past(dat_wdata_i)));

  // R3
  sel_none_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && sel_q == 2'd3) |=> ($stable(oe_o) && $stable(lvl_o) && $stable(pu_o)));

  // R5
  pu_on_driven_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pu_o & oe_o) == '0);

  // R8
  latch_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsrc_q |-> (port_rdata_o == out_o));

  if (SYNC_BASE == 2 && SYNC_EXTRA == 2) begin : g_lat
    // R6
    pin_lat_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q >= 3'd4 && !rsrc_q && !sync_xtra_i) |-> (port_rdata_o == $past(pin_i, 2)));
    // R7
    pin_lat_xtra_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (age_q >= 3'd6 && !rsrc_q && sync_xtra_i) |-> (port_rdata_o == $past(pin_i, 4)));
  end
endmodule

bind gpio_port gpio_port_chk #(.W(W), .SYNC_BASE(SYNC_BASE), .SYNC_EXTRA(SYNC_EXTRA)) u_chk (
  .clk          (clk),
  .rst_n        (rst_q_n),
  .dat_we_i     (dat_we_i),
  .dat_wdata_i  (dat_wdata_i),
  .cfg_we_i     (cfg_we_i),
  .sel_q        (sel_q),
  .rsrc_q       (rsrc_q),
  .sync_xtra_i  (sync_xtra_i),
  .pin_i        (pin_i),
  .port_rdata_o (port_rdata_o),
  .oe_o         (oe_o),
  .out_o        (out_o),
  .lvl_o        (lvl_o),
  .pu_o         (pu_o)
);

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sel_we_i = 1'b0, rsrc_we_i = 1'b0, dat_we_i = 1'b0, cfg_we_i = 1'b0;
  logic [1:0]   sel_wdata_i = 2'd0;
  logic         rsrc_wdata_i = 1'b0, sync_xtra_i = 1'b0;
  logic [W-1:0] dat_wdata_i = '0, cfg_wdata_i = '0, pin_i = '0;
  logic [W-1:0] cfg_rdata_o, port_rdata_o, oe_o, out_o, lvl_o, pu_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gpio_port #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .sel_we_i(sel_we_i), .sel_wdata_i(sel_wdata_i),
    .rsrc_we_i(rsrc_we_i), .rsrc_wdata_i(rsrc_wdata_i),
    .dat_we_i(dat_we_i), .dat_wdata_i(dat_wdata_i),
    .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
    .sync_xtra_i(sync_xtra_i), .pin_i(pin_i),
    .cfg_rdata_o(cfg_rdata_o), .port_rdata_o(port_rdata_o),
    .oe_o(oe_o), .out_o(out_o), .lvl_o(lvl_o), .pu_o(pu_o)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_sel(logic [1:0] v);
    sel_we_i = 1'b1; sel_wdata_i = v; tick(1); sel_we_i = 1'b0;
  endtask

  task automatic set_rsrc(logic v);
    rsrc_we_i = 1'b1; rsrc_wdata_i = v; tick(1); rsrc_we_i = 1'b0;
  endtask

  task automatic wr_data(logic [W-1:0] v);
    dat_we_i = 1'b1; dat_wdata_i = v; tick(1); dat_we_i = 1'b0;
  endtask

  task automatic wr_cfg(logic [1:0] s, logic [W-1:0] v);
    set_sel(s);
    cfg_we_i = 1'b1; cfg_wdata_i = v; tick(1); cfg_we_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 oe", oe_o, 8'h00);
    check("R1 out", out_o, 8'h00);
    check("R1 lvl", lvl_o, 8'h00);
    check("R1 pu", pu_o, 8'h00);
    check("R1 cfg read dir", cfg_rdata_o, 8'hFF);
  endtask

  task automatic t_data_dir();
    wr_data(8'h3C);
    check("R2 out", out_o, 8'h3C);
    wr_cfg(2'd0, 8'h0F);
    check("R2 oe", oe_o, 8'hF0);
  endtask

  task automatic t_banks();
    wr_cfg(2'd1, 8'h96);
    check("R3 lvl", lvl_o, 8'h96);
    check("R4 read lvl", cfg_rdata_o, 8'h96);
    wr_cfg(2'd2, 8'hFF);
    check("R4 read pu", cfg_rdata_o, 8'hFF);
    check("R3 dir untouched", oe_o, 8'hF0);
    wr_cfg(2'd3, 8'h00);
    check("R3 none lvl", lvl_o, 8'h96);
    check("R3 none oe", oe_o, 8'hF0);
    check("R4 read none", cfg_rdata_o, 8'h00);
    set_sel(2'd0);
    check("R4 read dir", cfg_rdata_o, 8'h0F);
  endtask

  task automatic t_pullup();
    check("R5 gated", pu_o, 8'h0F);
    wr_cfg(2'd0, 8'hFF);
    check("R5 all inputs", pu_o, 8'hFF);
    wr_cfg(2'd2, 8'h00);
    check("R5 off", pu_o, 8'h00);
  endtask

  task automatic t_pin_base();
    set_rsrc(1'b0);
    sync_xtra_i = 1'b0;
    pin_i = 8'h00; tick(6);
    pin_i = 8'hA7;
    tick(1); check("R6 stale after 1", port_rdata_o, 8'h00);
    tick(1); check("R6 new after 2", port_rdata_o, 8'hA7);
  endtask

  task automatic t_pin_xtra();
    sync_xtra_i = 1'b1;
    pin_i = 8'h11; tick(6);
    pin_i = 8'hE2;
    tick(3); check("R7 stale after 3", port_rdata_o, 8'h11);
    tick(1); check("R7 new after 4", port_rdata_o, 8'hE2);
    sync_xtra_i = 1'b0;
  endtask

  task automatic t_latch_rmw();
    set_rsrc(1'b1);
    wr_data(8'h01);
    check("R8 first", port_rdata_o, 8'h01);
    wr_data(port_rdata_o | 8'h80);
    check("R8 back-to-back", port_rdata_o, 8'h81);
  endtask

  task automatic t_forced();
    wr_cfg(2'd0, 8'h00);
    wr_data(8'hA5);
    pin_i = 8'h5A;
    set_rsrc(1'b0);
    tick(3);
    check("R9 pin mode", port_rdata_o, 8'h5A);
    set_rsrc(1'b1);
    check("R9 latch mode", port_rdata_o, 8'hA5);
  endtask

  initial begin
    #10000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_data_dir();
    t_banks();
    t_pullup();
    t_pin_base();
    t_pin_xtra();
    t_latch_rmw();
    t_forced();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule